// File: doc/BRIEF.md
# Endpoint Control Register Bank

This block holds eight 32-bit control and status words, one for each endpoint or host channel of a full-speed USB controller. Software reaches them through a simple register bus, one word every four bytes. A packet engine beside the bank drives per-endpoint strobes. These strobes raise completion and error flags, mark SETUP receptions, load the handshake status fields and flip the data toggles.

Every word mixes four kinds of bit:

- plain read/write fields;
- a read-only SETUP marker;
- flags that software clears by writing zero;
- fields that software flips by writing one.

Writing one to a clearable flag, or zero to a flippable field, leaves that bit alone. This gives a fixed "leave it" pattern for the hardware-owned bits. Software can therefore change any single field with one store, and that store cannot undo a hardware update that arrived after the last read.

A USB bus reset input clears every word in one cycle, except the two transfer-complete flags.

Top module: `ep_ctrl_bank`

## Requirements
- R1: After rstN is asserted low, every endpoint word reads 0x0000_0000.
- R2: Byte address bits [7:2] select endpoint word n = addr[7:2] for n from 0 to 7, and addr[1:0] are ignored. A write whose selected index is 8 or more changes no word, and reading such an address returns zero.
- R3: The plain fields take the written value on a write to their word. These fields are the endpoint number [3:0], KIND [8], endpoint type [10:9], device address [22:16] and low-speed [24].
- R4: The clear-on-zero flags are rxDone [15], txDone [7], nakFlag [23], txErr [25] and rxErr [26]. Writing 0 to one of them clears it, and writing 1 leaves it unchanged.
- R5: A hardware set strobe sets its flag. If a software write of 0 to that flag happens in the same cycle, the flag still ends up set.
- R6: The flippable fields are rxToggle [14], rxStat [13:12], txToggle [6] and txStat [5:4]. Writing 1 inverts a bit and writing 0 keeps it. A hardware load or toggle in the same cycle is applied first, and the software flip is then applied to the result.
- R7: SETUP [11] ignores bus writes. The SETUP strobe sets it, and an rxDone strobe without the SETUP strobe clears it. Bits [31:27] always read zero.
- R8: A write of 0x0680_8080 (ones on clear-on-zero flags, zeros on flippable fields) leaves every hardware-owned bit exactly as the hardware strobes of that cycle leave it. Those strobes include a flag set or a toggle arriving in the same cycle.
- R9: While usbReset is high, bus writes are ignored and every bit is cleared except rxDone and txDone. Those two flags keep their value, and a set strobe for them in that cycle still takes effect.
- R10: rdData follows addr combinationally and needs no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usbReset | input | 1 | USB bus reset or software-forced reset |
| wrEn | input | 1 | Register write enable |
| addr | input | 8 | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| hwSetRxDone | input | 8 | Per-endpoint receive-complete set strobe |
| hwSetTxDone | input | 8 | Per-endpoint transmit-complete set strobe |
| hwSetNak | input | 8 | Per-endpoint NAK flag set strobe |
| hwSetRxErr | input | 8 | Per-endpoint receive error set strobe |
| hwSetTxErr | input | 8 | Per-endpoint transmit error set strobe |
| hwSetSetup | input | 8 | Per-endpoint SETUP reception strobe |
| hwLoadRxStat | input | 8 | Per-endpoint receive status load strobe |
| hwRxStatVal | input | 16 | New receive status, 2 bits per endpoint |
| hwLoadTxStat | input | 8 | Per-endpoint transmit status load strobe |
| hwTxStatVal | input | 16 | New transmit status, 2 bits per endpoint |
| hwFlipRxToggle | input | 8 | Per-endpoint receive data toggle strobe |
| hwFlipTxToggle | input | 8 | Per-endpoint transmit data toggle strobe |

## Verification
Directed stores of all-ones, all-zeros, the invariant pattern and single-flag clears are made on one endpoint. Each is timed against hardware strobes in the same cycle. These tests separate the correct merge order from one where software wins or where a flip lands before a hardware load. Writes to out-of-range and unaligned addresses show whether decoding uses only the word index. A bus reset that coincides with a write and a completion strobe shows which bits survive. A long run of random writes, random strobes and occasional resets across all eight endpoints is then compared word by word against an arithmetic model of the per-bit rules.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  localparam int EP_COUNT = 8;
  localparam int IDX_W    = $clog2(EP_COUNT);
  localparam int WORD_W   = 32;

  localparam int BIT_RXDONE = 15;
  localparam int BIT_RXTOG  = 14;
  localparam int RXSTAT_LO  = 12;
  localparam int BIT_SETUP  = 11;
  localparam int BIT_TXDONE = 7;
  localparam int BIT_TXTOG  = 6;
  localparam int TXSTAT_LO  = 4;
  localparam int BIT_NAK    = 23;
  localparam int BIT_TXERR  = 25;
  localparam int BIT_RXERR  = 26;

  localparam logic [WORD_W-1:0] RW_MASK   = 32'h017F_070F;
  localparam logic [WORD_W-1:0] CLR0_MASK = 32'h0680_8080;
  localparam logic [WORD_W-1:0] FLIP_MASK = 32'h0000_7070;
  localparam logic [WORD_W-1:0] RO_MASK   = 32'h0000_0800;
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h0000_8080;
  localparam logic [WORD_W-1:0] RSV_MASK  = ~(RW_MASK | CLR0_MASK | FLIP_MASK | RO_MASK);
  localparam logic [WORD_W-1:0] HOLD_PATTERN = CLR0_MASK;

  typedef struct packed {
    logic [EP_COUNT-1:0] wrSel;
    logic                busClr;
    logic                rdHit;
    logic [IDX_W-1:0]    rdIdx;
  } bankStrobes_t;
endpackage

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              usbReset,
  output bankStrobes_t      strb
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slotIdx;
  logic              inRange;

  assign slotIdx = addr[ADDR_W-1:2];
  assign inRange = int'(slotIdx) < EP_COUNT;

  assign strb.busClr = usbReset;
  assign strb.rdHit  = inRange;
  assign strb.rdIdx  = slotIdx[IDX_W-1:0];

  for (genvar i = 0; i < EP_COUNT; i++) begin : g_sel
    assign strb.wrSel[i] = wrEn && !usbReset && inRange && (int'(slotIdx) == i);
  end
endmodule

// File: rtl/ep_bank_regs.sv
module ep_bank_regs
  import ep_bank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  bankStrobes_t             strb,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [EP_COUNT-1:0]      hwSetRxDone,
  input  logic [EP_COUNT-1:0]      hwSetTxDone,
  input  logic [EP_COUNT-1:0]      hwSetNak,
  input  logic [EP_COUNT-1:0]      hwSetRxErr,
  input  logic [EP_COUNT-1:0]      hwSetTxErr,
  input  logic [EP_COUNT-1:0]      hwSetSetup,
  input  logic [EP_COUNT-1:0]      hwLoadRxStat,
  input  logic [2*EP_COUNT-1:0]    hwRxStatVal,
  input  logic [EP_COUNT-1:0]      hwLoadTxStat,
  input  logic [2*EP_COUNT-1:0]    hwTxStatVal,
  input  logic [EP_COUNT-1:0]      hwFlipRxToggle,
  input  logic [EP_COUNT-1:0]      hwFlipTxToggle,
  output logic [WORD_W-1:0]        rdData,
  output logic [EP_COUNT*WORD_W-1:0] epFlat
);
  logic [EP_COUNT-1:0][WORD_W-1:0] regQ;

  for (genvar i = 0; i < EP_COUNT; i++) begin : g_ep
    logic [WORD_W-1:0] cur, nxt;

    always_comb begin
      nxt = cur;
      // software clear first so a same-cycle hardware set wins
      if (strb.wrSel[i]) nxt = nxt & (wrData | ~CLR0_MASK);
      if (hwSetRxDone[i]) nxt[BIT_RXDONE] = 1'b1;
      if (hwSetTxDone[i]) nxt[BIT_TXDONE] = 1'b1;
      if (hwSetNak[i])    nxt[BIT_NAK]    = 1'b1;
      if (hwSetRxErr[i])  nxt[BIT_RXERR]  = 1'b1;
      if (hwSetTxErr[i])  nxt[BIT_TXERR]  = 1'b1;
      if (hwSetSetup[i])       nxt[BIT_SETUP] = 1'b1;
      else if (hwSetRxDone[i]) nxt[BIT_SETUP] = 1'b0;
      // hardware status/toggle updates precede the software flip
      if (hwLoadRxStat[i])   nxt[RXSTAT_LO +: 2] = hwRxStatVal[2*i +: 2];
      if (hwLoadTxStat[i])   nxt[TXSTAT_LO +: 2] = hwTxStatVal[2*i +: 2];
      if (hwFlipRxToggle[i]) nxt[BIT_RXTOG] = ~nxt[BIT_RXTOG];
      if (hwFlipTxToggle[i]) nxt[BIT_TXTOG] = ~nxt[BIT_TXTOG];
      if (strb.wrSel[i]) begin
        nxt = nxt ^ (wrData & FLIP_MASK);
        nxt = (nxt & ~RW_MASK) | (wrData & RW_MASK);
      end
      if (strb.busClr) begin
        nxt = '0;
        nxt[BIT_RXDONE] = cur[BIT_RXDONE] | hwSetRxDone[i];
        nxt[BIT_TXDONE] = cur[BIT_TXDONE] | hwSetTxDone[i];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cur <= '0;
      else       cur <= nxt;
    end

    assign regQ[i] = cur;
    assign epFlat[i*WORD_W +: WORD_W] = cur;
  end

  assign rdData = strb.rdHit ? regQ[strb.rdIdx] : '0;
endmodule

// File: rtl/ep_ctrl_bank.sv
module ep_ctrl_bank
  import ep_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  usbReset,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  input  logic [EP_COUNT-1:0]   hwSetRxDone,
  input  logic [EP_COUNT-1:0]   hwSetTxDone,
  input  logic [EP_COUNT-1:0]   hwSetNak,
  input  logic [EP_COUNT-1:0]   hwSetRxErr,
  input  logic [EP_COUNT-1:0]   hwSetTxErr,
  input  logic [EP_COUNT-1:0]   hwSetSetup,
  input  logic [EP_COUNT-1:0]   hwLoadRxStat,
  input  logic [2*EP_COUNT-1:0] hwRxStatVal,
  input  logic [EP_COUNT-1:0]   hwLoadTxStat,
  input  logic [2*EP_COUNT-1:0] hwTxStatVal,
  input  logic [EP_COUNT-1:0]   hwFlipRxToggle,
  input  logic [EP_COUNT-1:0]   hwFlipTxToggle
);
  bankStrobes_t                 strb;
  logic [EP_COUNT*WORD_W-1:0]   epFlat;

  ep_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .usbReset(usbReset), .strb(strb)
  );

  ep_bank_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .hwSetRxDone(hwSetRxDone), .hwSetTxDone(hwSetTxDone), .hwSetNak(hwSetNak),
    .hwSetRxErr(hwSetRxErr), .hwSetTxErr(hwSetTxErr), .hwSetSetup(hwSetSetup),
    .hwLoadRxStat(hwLoadRxStat), .hwRxStatVal(hwRxStatVal),
    .hwLoadTxStat(hwLoadTxStat), .hwTxStatVal(hwTxStatVal),
    .hwFlipRxToggle(hwFlipRxToggle), .hwFlipTxToggle(hwFlipTxToggle),
    .rdData(rdData), .epFlat(epFlat)
  );
endmodule

// File: rtl/ep_ctrl_bank_chk.sv
module ep_ctrl_bank_chk
  import ep_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       usbReset,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          addr,
  input logic [31:0]                wrData,
  input logic [31:0]                rdData,
  input logic [EP_COUNT-1:0]        hwSetRxDone,
  input logic [EP_COUNT-1:0]        hwSetTxDone,
  input logic [EP_COUNT-1:0]        hwSetNak,
  input logic [EP_COUNT-1:0]        hwSetRxErr,
  input logic [EP_COUNT-1:0]        hwSetTxErr,
  input logic [EP_COUNT-1:0]        hwSetSetup,
  input logic [EP_COUNT-1:0]        hwLoadRxStat,
  input logic [EP_COUNT-1:0]        hwLoadTxStat,
  input logic [EP_COUNT-1:0]        hwFlipRxToggle,
  input logic [EP_COUNT-1:0]        hwFlipTxToggle,
  input logic [EP_COUNT*WORD_W-1:0] epFlat
);
  localparam logic [WORD_W-1:0] HW_OWNED = CLR0_MASK | FLIP_MASK | RO_MASK;

  assert_oob_read_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr[ADDR_W-1:2]) >= EP_COUNT) |-> (rdData == '0));

  for (genvar i = 0; i < EP_COUNT; i++) begin : g_chk
    logic quietHw;
    assign quietHw = !(hwSetRxDone[i] | hwSetTxDone[i] | hwSetNak[i] | hwSetRxErr[i] |
                       hwSetTxErr[i] | hwSetSetup[i] | hwLoadRxStat[i] | hwLoadTxStat[i] |
                       hwFlipRxToggle[i] | hwFlipTxToggle[i]);

    assert_hw_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
      hwSetRxDone[i] |=> epFlat[i*WORD_W + BIT_RXDONE]);

    assert_setup_readonly_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!usbReset && !hwSetSetup[i] && !hwSetRxDone[i]) |=> $stable(epFlat[i*WORD_W + BIT_SETUP]));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
      (epFlat[i*WORD_W +: WORD_W] & RSV_MASK) == '0);

    assert_invariant_store_R8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !usbReset && quietHw && (int'(addr[ADDR_W-1:2]) == i) && (wrData == HOLD_PATTERN))
      |=> $stable(epFlat[i*WORD_W +: WORD_W] & HW_OWNED));

    assert_bus_reset_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      usbReset |=> ((epFlat[i*WORD_W +: WORD_W] & ~KEEP_MASK) == '0));
  end
endmodule

bind ep_ctrl_bank ep_ctrl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ep_ctrl_bank_tb.sv
`timescale 1ns/1ps
module ep_ctrl_bank_tb;
  import ep_bank_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usbReset = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  hwSetRxDone = '0, hwSetTxDone = '0, hwSetNak = '0, hwSetRxErr = '0;
  logic [7:0]  hwSetTxErr = '0, hwSetSetup = '0, hwLoadRxStat = '0, hwLoadTxStat = '0;
  logic [7:0]  hwFlipRxToggle = '0, hwFlipTxToggle = '0;
  logic [15:0] hwRxStatVal = '0, hwTxStatVal = '0;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [8];

  always #4 clk = ~clk;

  ep_ctrl_bank u_dut (.*);

  function automatic logic [31:0] nextWord(input logic [31:0] q, input int e);
    logic [31:0] d;
    logic hit;
    hit = wrEn && !usbReset && (int'(addr >> 2) == e);
    if (usbReset) begin
      d = '0;
      d[15] = q[15] | hwSetRxDone[e];
      d[7]  = q[7]  | hwSetTxDone[e];
      return d;
    end
    d = q;
    if (hit) d = d & (wrData | 32'hF97F_7F7F);
    d[15] = d[15] | hwSetRxDone[e];
    d[7]  = d[7]  | hwSetTxDone[e];
    d[23] = d[23] | hwSetNak[e];
    d[26] = d[26] | hwSetRxErr[e];
    d[25] = d[25] | hwSetTxErr[e];
    if (hwSetSetup[e]) d[11] = 1'b1;
    else if (hwSetRxDone[e]) d[11] = 1'b0;
    if (hwLoadRxStat[e]) d[13:12] = hwRxStatVal[2*e +: 2];
    if (hwLoadTxStat[e]) d[5:4]   = hwTxStatVal[2*e +: 2];
    d[14] = d[14] ^ hwFlipRxToggle[e];
    d[6]  = d[6]  ^ hwFlipTxToggle[e];
    if (hit) begin
      d = d ^ (wrData & 32'h0000_7070);
      d = (d & ~32'h017F_070F) | (wrData & 32'h017F_070F);
    end
    return d;
  endfunction

  task automatic idle();
    usbReset = 0; wrEn = 0; wrData = '0;
    hwSetRxDone = '0; hwSetTxDone = '0; hwSetNak = '0; hwSetRxErr = '0;
    hwSetTxErr = '0; hwSetSetup = '0; hwLoadRxStat = '0; hwLoadTxStat = '0;
    hwFlipRxToggle = '0; hwFlipTxToggle = '0; hwRxStatVal = '0; hwTxStatVal = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    for (int e = 0; e < 8; e++) model[e] = nextWord(model[e], e);
    @(negedge clk);
    idle();
  endtask

  task automatic readAt(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; wrEn = 0;
    #1;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", req, a, rdData, exp);
    end
  endtask

  task automatic store(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 8; e++) model[e] = '0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    for (int e = 0; e < 8; e++) readAt("R1 reset value", 8'(4*e), 32'h0);

    // R3 R6 R7: all-ones store flips toggles, sets plain fields, not SETUP/reserved
    store(8'h0C, 32'hFFFF_FFFF); tick();
    readAt("R3/R6/R7 all-ones store", 8'h0C, 32'h017F_777F);
    store(8'h0C, 32'hFFFF_FFFF); tick();
    readAt("R6 second all-ones flips back", 8'h0C, 32'h017F_070F);

    // R5: hardware sets beat same-cycle zero writes
    store(8'h0C, 32'h0);
    hwSetRxDone[3] = 1; hwSetTxDone[3] = 1; hwSetNak[3] = 1;
    hwSetRxErr[3] = 1; hwSetTxErr[3] = 1; hwSetSetup[3] = 1;
    tick();
    readAt("R5 set beats clear", 8'h0C, 32'h0680_8880);

    // R4: clear NAK only
    store(8'h0C, 32'h0600_8080); tick();
    readAt("R4 single flag clear", 8'h0C, 32'h0600_8880);

    // R8: invariant store with a hardware toggle in the same cycle
    store(8'h0C, 32'h0680_808F); hwFlipRxToggle[3] = 1; tick();
    readAt("R8 invariant with hw toggle", 8'h0C, 32'h0600_C88F);

    // R6: hw load then sw flip in the same cycle
    store(8'h0C, 32'h0680_809F); hwLoadTxStat[3] = 1; hwTxStatVal[7:6] = 2'b01; tick();
    readAt("R6 hw load then sw flip", 8'h0C, 32'h0600_C88F);

    // R2: out-of-range writes ignored, reads zero
    store(8'h20, 32'hFFFF_FFFF); tick();
    store(8'hFC, 32'h0000_0000); tick();
    readAt("R2 out-of-range no effect", 8'h0C, 32'h0600_C88F);
    readAt("R2 out-of-range read 0x20", 8'h20, 32'h0);
    readAt("R2 out-of-range read 0xFC", 8'hFC, 32'h0);

    // R2 R3: low address bits ignored
    store(8'h0E, 32'h0681_8080); tick();
    readAt("R2/R3 unaligned address", 8'h0C, 32'h0601_C880);

    // R7: rxDone strobe alone clears SETUP; writes to SETUP/reserved ignored
    hwSetRxDone[3] = 1; tick();
    store(8'h0C, 32'hFE81_8880); tick();
    readAt("R7 setup and reserved ignore writes", 8'h0C, 32'h0601_C080);

    // R9: bus reset
    hwSetRxDone[5] = 1; hwSetTxDone[5] = 1; hwSetNak[5] = 1; hwSetSetup[5] = 1; tick();
    store(8'h14, 32'hFFFF_FFFF); usbReset = 1; hwSetRxDone[6] = 1; tick();
    readAt("R9 reset keeps done flags ep5", 8'h14, 32'h0000_8080);
    readAt("R9 reset accepts set ep6", 8'h18, 32'h0000_8000);
    readAt("R9 reset clears ep3 fields", 8'h0C, 32'h0000_8080);

    // R10: combinational readback across addresses without a clock edge
    readAt("R10 comb read ep6", 8'h18, 32'h0000_8000);
    readAt("R10 comb read ep0", 8'h00, 32'h0);

    // Random sweep against the arithmetic model
    for (int n = 0; n < 4000; n++) begin
      for (int e = 0; e < 8; e++) begin
        hwSetRxDone[e]    = ($urandom % 8) == 0;
        hwSetTxDone[e]    = ($urandom % 8) == 0;
        hwSetNak[e]       = ($urandom % 8) == 0;
        hwSetRxErr[e]     = ($urandom % 10) == 0;
        hwSetTxErr[e]     = ($urandom % 10) == 0;
        hwSetSetup[e]     = ($urandom % 10) == 0;
        hwLoadRxStat[e]   = ($urandom % 8) == 0;
        hwLoadTxStat[e]   = ($urandom % 8) == 0;
        hwFlipRxToggle[e] = ($urandom % 6) == 0;
        hwFlipTxToggle[e] = ($urandom % 6) == 0;
      end
      hwRxStatVal = 16'($urandom);
      hwTxStatVal = 16'($urandom);
      wrEn   = ($urandom % 2) == 0;
      addr   = 8'($urandom % 48);
      wrData = $urandom;
      if (($urandom % 3) == 0) wrData = wrData | 32'h0680_8080;
      usbReset = ($urandom % 150) == 0;
      tick();
      for (int e = 0; e < 8; e++)
        readAt("R3/R4/R5/R6/R9 random sweep", 8'(4*e), model[e]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule